// File: doc/BRIEF.md
# Distributed Pipelined Bus Arbiter Node

Each agent on a shared bus carries one copy of this node. The agent drives a single request wire and watches the request wires of the agents ranked below it. Every copy runs the same decision on the same sampled inputs, so all copies pick the same next owner and no central arbiter is needed. A three-bit permission code from the memory controller and a shared hold line from the current owner also feed the decision.

The decision is pipelined in three stages. In cycle t the wires are sampled, in cycle t+1 `grant_o` shows the winner, and in cycle t+2 `drive_o` enables that agent's bus drivers. A new owner can be chosen every cycle. The ranking, from highest to lowest, is: the owner holding the bus, then the memory controller when the code claims the slot, then the I/O adapter, then up to four processors that take turns. Parameter `ROLE` selects memory controller (0), I/O adapter (1) or processor (2), and `CPU_ID` gives a processor its index. A memory node uses only the code and the hold line. An I/O node does not consult the processor wires.

Top module: `bus_arb_node`

## Requirements
- R1: An agent that is not contested and asserts its request in cycle t sees `grant_o` high in cycle t+1 and `drive_o` high in cycle t+2. An I/O or processor node with no request and no hold line asserted is not granted in the following cycle.
- R2: Permission code 2 hands the next slot to the memory node, ahead of the I/O adapter and the processors, whatever their wires show. With any other code and no hold, the memory node is not granted.
- R3: When no hold and no blocking code is present, the I/O request wins over all processor requests. A processor is never granted in the cycle after the I/O wire was high without a hold.
- R4: Processors are served in rotating order. After reset the scan starts at processor 0. After processor k wins, the scan starts at processor k+1, wrapping to 0 after the last one.
- R5: The rotation pointer moves only when a processor wins. A win by the memory node or the I/O adapter leaves it unchanged.
- R6: An agent that is granted in a cycle and raises its hold request in that same cycle keeps the following slot, ahead of a memory claim.
- R7: Hold extensions in a row are capped at `HOLD_MAX` (default 4), so a holder gets at most `HOLD_MAX`+1 consecutive slots. The next slot is then decided by normal ranking.
- R8: Permission code 1 blocks every grant except a hold extension. Codes 0, 3 to 7 allow normal arbitration.
- R9: Across all nodes on one bus, at most one `drive_o` is high in any cycle.
- R10: During and right after reset, `grant_o`, `drive_o` and `long_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| want_i | input | 1 | This agent wants a slot |
| hold_want_i | input | 1 | This agent wants to keep the bus for the next slot |
| io_line_i | input | 1 | I/O adapter request wire |
| cpu_lines_i | input | NUM_CPU | Processor request wires, bit k for processor k |
| perm_i | input | 3 | Permission code: 1 blocks, 2 memory claims, others open |
| long_line_i | input | 1 | Shared hold line, the OR of every node's `long_o` |
| req_o | output | 1 | This agent's request wire |
| long_o | output | 1 | Hold line contribution, high only while granted |
| grant_o | output | 1 | This node won the decision this cycle |
| drive_o | output | 1 | Bus drivers enabled this cycle |

## Verification
Some rules are checked by bound properties in every cycle. A blocking code suppresses grants. The memory node is granted exactly when it claims the slot. No grant goes to a node that did not request. A processor never beats the I/O wire. A hold chain under a blocking code ends after the cap. Other behaviour can only be shown by the bench's scenarios and its cycle-by-cycle reference model of all six nodes: the rotation order, a pointer that stays put on non-processor wins, a hold that beats a memory claim, the two-cycle latency, and the agreement that gives a single driver per cycle.

// File: rtl/bus_arb_node.sv
`timescale 1ns/1ps
module bus_arb_node #(
  parameter int NUM_CPU  = 4,
  parameter int HOLD_MAX = 4,
  parameter int ROLE     = 2,
  parameter int CPU_ID   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want_i,
  input  logic               hold_want_i,
  input  logic               io_line_i,
  input  logic [NUM_CPU-1:0] cpu_lines_i,
  input  logic [2:0]         perm_i,
  input  logic               long_line_i,
  output logic               req_o,
  output logic               long_o,
  output logic               grant_o,
  output logic               drive_o
);

  localparam int PW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int CW = $clog2(HOLD_MAX + 2);
  localparam logic [2:0] PERM_QUIET = 3'd1;
  localparam logic [2:0] PERM_MEM   = 3'd2;
  localparam int ROLE_MEM = 0;
  localparam int ROLE_IO  = 1;

  logic               s_want, s_io, s_long, s_mine;
  logic [NUM_CPU-1:0] s_cpu;
  logic [2:0]         s_perm;
  logic [CW-1:0]      hold_cnt;
  logic [PW-1:0]      rr_ptr, pick_idx, scan;
  logic               pick_ok, hold_on, open, cpu_turn, base;

  assign req_o  = want_i;
  assign long_o = grant_o & hold_want_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_want <= 1'b0;
      s_io   <= 1'b0;
      s_cpu  <= '0;
      s_perm <= '0;
      s_long <= 1'b0;
      s_mine <= 1'b0;
    end else begin
      s_want <= want_i;
      s_io   <= io_line_i;
      s_cpu  <= cpu_lines_i;
      s_perm <= perm_i;
      s_long <= long_line_i;
      s_mine <= long_o;
    end
  end

  assign hold_on  = s_long && (hold_cnt < CW'(HOLD_MAX));
  assign open     = (s_perm != PERM_QUIET) && (s_perm != PERM_MEM);
  assign cpu_turn = !hold_on && open && !s_io && pick_ok;

  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    scan     = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      scan = PW'((int'(rr_ptr) + i) % NUM_CPU);
      if (!pick_ok && s_cpu[scan]) begin
        pick_ok  = 1'b1;
        pick_idx = scan;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      rr_ptr   <= '0;
      drive_o  <= 1'b0;
    end else begin
      hold_cnt <= hold_on ? hold_cnt + 1'b1 : '0;
      if (cpu_turn)
        rr_ptr <= (pick_idx == PW'(NUM_CPU - 1)) ? '0 : pick_idx + 1'b1;
      drive_o  <= grant_o;
    end
  end

  generate
    if (ROLE == ROLE_MEM) begin : g_mem
      assign base = (s_perm == PERM_MEM);
    end else if (ROLE == ROLE_IO) begin : g_io
      assign base = open && s_want;
    end else begin : g_cpu
      assign base = cpu_turn && s_want && (pick_idx == PW'(CPU_ID));
    end
  endgenerate

  assign grant_o = hold_on ? s_mine : base;

endmodule

// File: rtl/bus_arb_node_chk.sv
`timescale 1ns/1ps
module bus_arb_node_chk #(
  parameter int ROLE     = 2,
  parameter int HOLD_MAX = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       want_i,
  input logic       io_line_i,
  input logic       long_line_i,
  input logic [2:0] perm_i,
  input logic       grant_o
);

  localparam int CW = $clog2(HOLD_MAX + 2);
  localparam logic [2:0] QUIET = 3'd1;
  localparam logic [2:0] MEMC  = 3'd2;

  logic [CW-1:0] qrun;

  always_ff @(posedge clk) begin
    if (!rst_n) qrun <= '0;
    else if (long_line_i && perm_i == QUIET)
      qrun <= (qrun == CW'(HOLD_MAX)) ? qrun : qrun + 1'b1;
    else qrun <= '0;
  end

  p_quiet_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_i == QUIET && !long_line_i) |=> !grant_o);

  p_hold_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (long_line_i && perm_i == QUIET && qrun == CW'(HOLD_MAX)) |=> !grant_o);

  generate
    if (ROLE == 0) begin : g_mem
      p_mem_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_i == MEMC && !long_line_i) |=> grant_o);
      p_mem_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_i != MEMC && !long_line_i) |=> !grant_o);
    end else begin : g_req
      p_need_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!want_i && !long_line_i) |=> !grant_o);
    end
    if (ROLE == 2) begin : g_cpu
      p_io_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_line_i && !long_line_i) |=> !grant_o);
    end
  endgenerate

endmodule

bind bus_arb_node bus_arb_node_chk #(.ROLE(ROLE), .HOLD_MAX(HOLD_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .want_i(want_i), .io_line_i(io_line_i),
  .long_line_i(long_line_i), .perm_i(perm_i), .grant_o(grant_o)
);

// File: tb/sim_bus_arb_node.sv
`timescale 1ns/1ps
module sim_bus_arb_node;
  localparam int HOLD_MAX = 4;
  localparam logic [2:0] OPEN = 3'd0, QUIET = 3'd1, MEMC = 3'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] want = '0, holdw = '0;
  logic [2:0] perm = '0;
  logic [5:0] reqv, longv, grant, drive;
  logic long_bus;
  int errs = 0, checks = 0;
  int exp_g = -1, exp_d = -1, m_ptr = 0, m_hcnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign long_bus = |longv;

  bus_arb_node #(.HOLD_MAX(HOLD_MAX), .ROLE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .want_i(want[0]), .hold_want_i(holdw[0]),
    .io_line_i(reqv[1]), .cpu_lines_i(reqv[5:2]), .perm_i(perm), .long_line_i(long_bus),
    .req_o(reqv[0]), .long_o(longv[0]), .grant_o(grant[0]), .drive_o(drive[0]));
  bus_arb_node #(.HOLD_MAX(HOLD_MAX), .ROLE(1)) u_io (
    .clk(clk), .rst_n(rst_n), .want_i(want[1]), .hold_want_i(holdw[1]),
    .io_line_i(reqv[1]), .cpu_lines_i(reqv[5:2]), .perm_i(perm), .long_line_i(long_bus),
    .req_o(reqv[1]), .long_o(longv[1]), .grant_o(grant[1]), .drive_o(drive[1]));
  for (genvar k = 0; k < 4; k++) begin : g_cpu
    bus_arb_node #(.HOLD_MAX(HOLD_MAX), .ROLE(2), .CPU_ID(k)) u_cpu (
      .clk(clk), .rst_n(rst_n), .want_i(want[2+k]), .hold_want_i(holdw[2+k]),
      .io_line_i(reqv[1]), .cpu_lines_i(reqv[5:2]), .perm_i(perm), .long_line_i(long_bus),
      .req_o(reqv[2+k]), .long_o(longv[2+k]), .grant_o(grant[2+k]), .drive_o(drive[2+k]));
  end

  function automatic int who(input logic [5:0] v);
    int r = -1;
    for (int i = 0; i < 6; i++) if (v[i]) r = (r == -1) ? i : -2;
    return r;
  endfunction

  function automatic logic [5:0] hot(input int id);
    return (id >= 0) ? (6'b1 << id) : 6'b0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [5:0] w, input logic [5:0] h, input logic [2:0] p, input string tag);
    bit lng, hon;
    int win;
    want = w; holdw = h; perm = p;
    lng = (exp_g >= 0) && h[exp_g];
    hon = lng && (m_hcnt < HOLD_MAX);
    m_hcnt = hon ? m_hcnt + 1 : 0;
    win = -1;
    if (hon) win = exp_g;
    else if (p == MEMC) win = 0;
    else if (p != QUIET) begin
      if (w[1]) win = 1;
      else for (int i = 0; i < 4; i++) begin
        int k = (m_ptr + i) % 4;
        if (win < 0 && w[2+k]) begin win = 2 + k; m_ptr = (k + 1) % 4; end
      end
    end
    exp_d = exp_g;
    exp_g = win;
    @(posedge clk); #5;
    checks++;
    if (grant !== hot(exp_g) || drive !== hot(exp_d)) begin
      errs++;
      $display("FAIL %s grant=%b drive=%b expected grant=%b drive=%b", tag, grant, drive, hot(exp_g), hot(exp_d));
    end
    check($countones(drive) <= 1, "R9 single driver", $countones(drive), 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(6'b0, 6'b0, OPEN, "idle");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check(grant === 6'b0 && drive === 6'b0 && longv === 6'b0, "R10 reset outputs", int'({grant, drive}), 0);
    rst_n = 1'b1;
    idle(1);
    check(grant === 6'b0 && drive === 6'b0, "R10 after reset", int'({grant, drive}), 0);

    cyc(6'b111100, 6'b0, OPEN, "R4 first scan");
    check(who(grant) == 2, "R4 pointer starts at cpu0", who(grant), 2);
    idle(2);

    cyc(6'b001000, 6'b0, OPEN, "R1 request");
    check(who(grant) == 3, "R1 grant next cycle", who(grant), 3);
    cyc(6'b0, 6'b0, OPEN, "R1 drive");
    check(who(drive) == 3, "R1 drive two cycles after", who(drive), 3);
    idle(1);

    begin
      int seq[4] = '{4, 5, 2, 3};
      for (int i = 0; i < 4; i++) begin
        cyc(6'b111100, 6'b0, OPEN, "R4 rotation");
        check(who(grant) == seq[i], "R4 rotation order", who(grant), seq[i]);
      end
    end
    idle(2);

    cyc(6'b111110, 6'b0, OPEN, "R3 io first");
    check(who(grant) == 1, "R3 io beats cpus", who(grant), 1);
    cyc(6'b111100, 6'b0, OPEN, "R5 after io");
    check(who(grant) == 4, "R5 pointer kept across io win", who(grant), 4);
    idle(1);

    cyc(6'b111111, 6'b0, MEMC, "R2 memory claim");
    check(who(grant) == 0, "R2 memory beats all", who(grant), 0);
    cyc(6'b111100, 6'b0, OPEN, "R5 after memory");
    check(who(grant) == 5, "R5 pointer kept across memory win", who(grant), 5);
    idle(1);

    cyc(6'b111110, 6'b0, QUIET, "R8 blocked");
    check(who(grant) == -1, "R8 quiet code blocks", who(grant), -1);
    idle(2);

    cyc(6'b000100, 6'b000100, OPEN, "R6 start");
    check(who(grant) == 2, "R6 first slot", who(grant), 2);
    for (int i = 0; i < HOLD_MAX; i++) begin
      cyc(6'b000110, 6'b000100, MEMC, "R6 hold");
      check(who(grant) == 2, "R6 hold beats memory", who(grant), 2);
    end
    cyc(6'b000110, 6'b000100, MEMC, "R7 cap");
    check(who(grant) == 0, "R7 cap then normal ranking", who(grant), 0);
    idle(2);

    cyc(6'b001000, 6'b001000, OPEN, "R7 quiet start");
    for (int i = 0; i < HOLD_MAX; i++) cyc(6'b001000, 6'b001000, QUIET, "R7 quiet hold");
    check(who(grant) == 3, "R7 holder kept under quiet", who(grant), 3);
    cyc(6'b001000, 6'b001000, QUIET, "R7 quiet cap");
    check(who(grant) == -1, "R7 hold ends after cap", who(grant), -1);
    idle(2);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] w = 6'($urandom);
      logic [5:0] h = 6'($urandom) & 6'($urandom);
      logic [2:0] p = 3'($urandom_range(0, 5));
      cyc(w, h, p, "R9 random traffic");
    end
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule